// File: doc/BRIEF.md
# Image Sensor Parallel Timing Generator

This block generates the parallel video stream that a CMOS image sensor presents to a host: a frame strobe, a line strobe and a pixel data bus. All three are launched on the falling edge of the pixel clock. The block uses a free-running column counter and row counter to step through the active lines of a frame and then through the vertical blanking rows. Inside each row it produces the line strobe and the horizontal blanking gap. The pixel data comes from a test-pattern counter, so the stream can be checked without a real pixel array.

A pixel is valid only when the frame strobe and the line strobe are both high. A 2-bit line-strobe mode input selects between two behaviours. In the gated mode the line strobe stays low while the frame strobe is low. In the free-running mode the line strobe pulses once per row time through vertical blanking as well. The block samples a new mode value only between frames, so a frame never mixes the two formats.

Geometry parameters: `ACT_W` (pixels per line, default 1288), `ACT_H` (lines per frame, default 968), `HBLANK` (clocks of horizontal blanking per row, at least `LV_OFS`), `VBLANK` (blanking rows per frame, at least 1), `LV_OFS` (line strobe lead-in, default 6) and `DW` (data width, default 12).

Top module: `pix_timing_gen`

## Requirements
- R1: While rst_ni is low, fv_o, lv_o and data_o are all zero. The first falling edge after reset is released begins a frame, with fv_o high.
- R2: fv_o is high for exactly ACT_H row times and then low for VBLANK row times. One row time is ACT_W+HBLANK clocks, so the frame period is (ACT_H+VBLANK)*(ACT_W+HBLANK) clocks.
- R3: In every row, lv_o rises LV_OFS clocks after the start of the row and stays high for ACT_W clocks. On the first row of a frame, lv_o therefore rises LV_OFS clocks after fv_o rises.
- R4: Each row holds HBLANK clocks with lv_o low. While fv_o is high these clocks form the horizontal blanking.
- R5: data_o is zero in every cycle in which fv_o and lv_o are not both high.
- R6: On each valid pixel, data_o equals the number of valid pixels that came before it in the same frame, modulo 2^DW. This count restarts at zero every frame.
- R7: Mode code 2'b00 is the gated mode. The reserved codes 2'b10 and 2'b11 behave the same way. In this mode lv_o is low in every cycle in which fv_o is low.
- R8: Mode code 2'b01 is the free-running mode. In this mode lv_o also pulses during the vertical blanking rows, at the same column positions and with the same width as in the active rows.
- R9: lv_mode_i is sampled only on the last clock of a frame and applies to the whole of the following frame. A change in the middle of a frame has no effect on that frame, and the first frame after reset always uses the gated mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; outputs are launched on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lv_mode_i | input | 2 | Line strobe mode: 2'b01 free-running, other codes gated |
| fv_o | output | 1 | Frame valid strobe |
| lv_o | output | 1 | Line valid strobe |
| data_o | output | DW | Pixel data: test pattern when valid, zero otherwise |

## Verification
The case that is hardest to reach is a mode change that arrives part-way through a frame. It is also the only way to expose a mode latch that samples at the wrong moment. The stimulus therefore holds the free-running code through the reset release, to show that the first frame stays gated. It then flips the mode in the middle of a frame and applies the reserved codes at frame boundaries. A random phase follows, in which the mode changes on arbitrary cycles. A second, asynchronous reset asserted in the middle of a frame shows that the timing restarts from the frame start.

// File: rtl/pix_timing_pkg.sv
package pix_timing_pkg;
  typedef enum logic [1:0] {
    LVM_GATED = 2'b00,
    LVM_FREE  = 2'b01,
    LVM_RSV2  = 2'b10,
    LVM_RSV3  = 2'b11
  } lv_mode_e;

  function automatic logic lv_is_free(input lv_mode_e m);
    return m == LVM_FREE;
  endfunction
endpackage

// File: rtl/pix_wrap_ctr.sv
module pix_wrap_ctr #(
  parameter int unsigned MAX = 4,
  parameter int unsigned W   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP = W'(MAX - 1);

  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == TOP);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (en_i && last_o) cnt_q <= '0;
    else if (en_i)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pix_strobe_gen.sv
module pix_strobe_gen
  import pix_timing_pkg::*;
#(
  parameter int unsigned ACT_W  = 1288,
  parameter int unsigned ACT_H  = 968,
  parameter int unsigned LV_OFS = 6,
  parameter int unsigned CW     = 11,
  parameter int unsigned RW     = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    lv_mode_i,
  input  logic          frame_last_i,
  input  logic [CW-1:0] col_i,
  input  logic [RW-1:0] row_i,
  output logic          fv_d_o,
  output logic          lv_d_o
);
  localparam logic [CW:0]   LV_BEG = (CW+1)'(LV_OFS);
  localparam logic [CW:0]   LV_END = (CW+1)'(LV_OFS + ACT_W);
  localparam logic [RW-1:0] ROW_END = RW'(ACT_H);

  lv_mode_e mode_q;
  logic     in_frame, in_line;
  logic [CW:0] col_x;

  // mode changes only at the frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mode_q <= LVM_GATED;
    else if (frame_last_i) mode_q <= lv_mode_e'(lv_mode_i);
  end

  assign col_x    = {1'b0, col_i};
  assign in_frame = (row_i < ROW_END);
  assign in_line  = (col_x >= LV_BEG) && (col_x < LV_END);
  assign fv_d_o   = in_frame;
  assign lv_d_o   = in_line && (in_frame || lv_is_free(mode_q));
endmodule

// File: rtl/pix_pattern_gen.sv
module pix_pattern_gen #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          valid_i,
  output logic [DW-1:0] data_d_o
);
  logic [DW-1:0] pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pat_q <= '0;
    else if (clr_i)   pat_q <= '0;
    else if (valid_i) pat_q <= pat_q + 1'b1;
  end

  assign data_d_o = valid_i ? pat_q : '0;
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fv_d_i,
  input  logic          lv_d_i,
  input  logic [DW-1:0] data_d_i,
  output logic          fv_o,
  output logic          lv_o,
  output logic [DW-1:0] data_o
);
  // falling-edge launch gives the receiver a full half period of setup
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_o   <= 1'b0;
      lv_o   <= 1'b0;
      data_o <= '0;
    end else begin
      fv_o   <= fv_d_i;
      lv_o   <= lv_d_i;
      data_o <= data_d_i;
    end
  end
endmodule

// File: rtl/pix_timing_gen.sv
module pix_timing_gen #(
  parameter int unsigned ACT_W  = 1288,
  parameter int unsigned ACT_H  = 968,
  parameter int unsigned HBLANK = 112,
  parameter int unsigned VBLANK = 32,
  parameter int unsigned LV_OFS = 6,
  parameter int unsigned DW     = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    lv_mode_i,
  output logic          fv_o,
  output logic          lv_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned ROW_T      = ACT_W + HBLANK;
  localparam int unsigned FRAME_ROWS = ACT_H + VBLANK;
  localparam int unsigned CW = (ROW_T > 1) ? $clog2(ROW_T) : 1;
  localparam int unsigned RW = (FRAME_ROWS > 1) ? $clog2(FRAME_ROWS) : 1;

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          col_last, row_last, frame_last;
  logic          fv_d, lv_d;
  logic [DW-1:0] data_d;

  pix_wrap_ctr #(.MAX(ROW_T), .W(CW)) u_col (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1),
    .cnt_o(col), .last_o(col_last)
  );

  pix_wrap_ctr #(.MAX(FRAME_ROWS), .W(RW)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(col_last),
    .cnt_o(row), .last_o(row_last)
  );

  assign frame_last = col_last && row_last;

  pix_strobe_gen #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .LV_OFS(LV_OFS), .CW(CW), .RW(RW)
  ) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .lv_mode_i(lv_mode_i),
    .frame_last_i(frame_last), .col_i(col), .row_i(row),
    .fv_d_o(fv_d), .lv_d_o(lv_d)
  );

  pix_pattern_gen #(.DW(DW)) u_pat (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(frame_last),
    .valid_i(fv_d && lv_d), .data_d_o(data_d)
  );

  pix_out_stage #(.DW(DW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fv_d_i(fv_d), .lv_d_i(lv_d), .data_d_i(data_d),
    .fv_o(fv_o), .lv_o(lv_o), .data_o(data_o)
  );
endmodule

// File: rtl/pix_timing_chk.sv
module pix_timing_chk #(
  parameter int unsigned ACT_W  = 1288,
  parameter int unsigned ACT_H  = 968,
  parameter int unsigned HBLANK = 112,
  parameter int unsigned LV_OFS = 6,
  parameter int unsigned DW     = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fv_o,
  input logic          lv_o,
  input logic [DW-1:0] data_o
);
  localparam int unsigned ROW_T = ACT_W + HBLANK;
  localparam int unsigned FV_T  = ACT_H * ROW_T;
  localparam int unsigned LW    = $clog2(FV_T + 2) + 1;

  logic [LW-1:0] fv_len, lv_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_len <= '0;
      lv_len <= '0;
    end else begin
      fv_len <= fv_o ? fv_len + 1'b1 : '0;
      lv_len <= lv_o ? lv_len + 1'b1 : '0;
    end
  end

  p_data_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != '0) |-> (fv_o && lv_o));

  p_lv_offset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lv_o) && fv_o && (fv_len < LW'(ROW_T))) |-> (fv_len == LW'(LV_OFS)));

  p_lv_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lv_o) |-> (lv_len == LW'(ACT_W)));

  p_fv_height_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fv_o) |-> (fv_len == LW'(FV_T)));

  p_pattern_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fv_o && lv_o && $past(fv_o && lv_o)) |-> (data_o == DW'($past(data_o) + 1'b1)));
endmodule

bind pix_timing_gen pix_timing_chk #(
  .ACT_W(ACT_W), .ACT_H(ACT_H), .HBLANK(HBLANK), .LV_OFS(LV_OFS), .DW(DW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fv_o(fv_o), .lv_o(lv_o), .data_o(data_o)
);

// File: tb/tb_pix_timing_gen.sv
`timescale 1ns/100ps
module tb_pix_timing_gen;
  localparam int unsigned W   = 8;
  localparam int unsigned H   = 4;
  localparam int unsigned HB  = 8;
  localparam int unsigned VB  = 3;
  localparam int unsigned OFS = 6;
  localparam int unsigned DW  = 12;
  localparam int unsigned RT  = W + HB;
  localparam int unsigned FR  = H + VB;
  localparam int unsigned FL  = RT * FR;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [1:0]    lv_mode_i;
  logic          fv_o, lv_o;
  logic [DW-1:0] data_o;

  int          compared = 0;
  int          mismatched = 0;
  int unsigned k = 0;
  logic [1:0]  eff_mode = 2'b00;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pix_timing_gen #(
    .ACT_W(W), .ACT_H(H), .HBLANK(HB), .VBLANK(VB), .LV_OFS(OFS), .DW(DW)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lv_mode_i(lv_mode_i),
    .fv_o(fv_o), .lv_o(lv_o), .data_o(data_o)
  );

  function automatic logic exp_fv(int unsigned kk);
    return ((kk / RT) % FR) < H;
  endfunction

  function automatic logic exp_lv(int unsigned kk, logic [1:0] m);
    int unsigned col = kk % RT;
    logic inl = (col >= OFS) && (col < OFS + W);
    return inl && (exp_fv(kk) || (m == 2'b01));
  endfunction

  function automatic logic [DW-1:0] exp_data(int unsigned kk, logic [1:0] m);
    int unsigned row = (kk / RT) % FR;
    int unsigned col = kk % RT;
    if (!(exp_fv(kk) && exp_lv(kk, m))) return '0;
    return DW'(row * W + (col - OFS));
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  // one sample per clock, after the falling-edge launch
  task automatic step();
    @(negedge clk_i);
    #1;
    if (k % FL == 0 && k > 0) eff_mode = lv_mode_i;  // R9 frame-boundary sampling
    check("R2 fv", fv_o, exp_fv(k));
    if (!exp_fv(k)) check("R7/R8/R9 lv in vblank", lv_o, exp_lv(k, eff_mode));
    else            check("R3/R4 lv in frame", lv_o, exp_lv(k, eff_mode));
    if (exp_fv(k) && exp_lv(k, eff_mode)) check("R6 pattern", data_o, exp_data(k, eff_mode));
    else                                  check("R5 data idle", data_o, 0);
    k++;
  endtask

  task automatic run(int unsigned n, bit rnd);
    for (int unsigned i = 0; i < n; i++) begin
      step();
      if (rnd && ($urandom % 30 == 0)) lv_mode_i = 2'($urandom % 4);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_ni    = 1'b0;
    lv_mode_i = 2'b01;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 fv reset", fv_o, 0);
    check("R1 lv reset", lv_o, 0);
    check("R1 data reset", data_o, 0);
    rst_ni = 1'b1;
    // R9: free code held through reset, first frame still gated
    run(FL, 1'b0);
    // frame 1 free-running (R8); mid-frame change ignored (R9)
    run(FL / 2, 1'b0);
    lv_mode_i = 2'b00;
    run(FL - FL / 2, 1'b0);
    run(FL, 1'b0);               // frame 2 gated (R7)
    lv_mode_i = 2'b11;
    run(FL, 1'b0);               // reserved code, gated (R7)
    lv_mode_i = 2'b10;
    run(FL, 1'b0);
    lv_mode_i = 2'b01;
    run(FL, 1'b0);
    run(FL * 8 + 37, 1'b1);      // random mode changes
    // R1: asynchronous reset mid-frame
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R1 fv async reset", fv_o, 0);
    check("R1 lv async reset", lv_o, 0);
    check("R1 data async reset", data_o, 0);
    @(posedge clk_i);
    #1;
    lv_mode_i = 2'b01;
    k = 0;
    eff_mode = 2'b00;
    rst_ni = 1'b1;
    run(FL * 2 + 5, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule